// File: doc/BRIEF.md
# Reversible-Gate Adder/Subtractor

This block adds or subtracts two N-bit operands (16 by default) using only two reversible logic primitives. One is a three-wire gate that copies its first input and XORs it into the other two. The other is a four-wire full-adder gate. The mode input decides the operation. When the mode is low, a row of XOR gates passes the B operand through unchanged and the ripple chain computes A + B + carry-in. When the mode is high, the same gates invert every B bit and the carry into bit 0 is forced high, so the chain computes A - B in two's complement.

Outputs that no later stage uses are not discarded. They leave the block on a garbage vector of 2N+1 bits. The bit order of that vector is fixed, so that a downstream stage could reverse the computation. The block has no clock or state.

The cost figures of the structure are exposed as elaboration-time constants of the top module, derived from N:
- the number of gates,
- the number of constant (ancilla) inputs,
- the number of garbage outputs,
- the quantum cost.

A generic equation layer can read these constants.

Top module: `rev_addsub`

## Requirements
- R1: The XOR primitive maps inputs (p, q, r) to outputs (p, p^q, p^r) and is a bijection on its 8 input patterns. In the datapath, a low mode leaves each conditioned B bit equal to the B input and a high mode inverts it.
- R2: The full-adder primitive maps inputs (a, b, c, d) to outputs (a, b, a^b^c, ((a^b)&c)^(a&b)^d) and is a bijection on its 16 input patterns. Its d input is a constant 0 ancilla in the datapath.
- R3: With mode = 0, {carry_out, result} equals A + B + carry_in as an (N+1)-bit unsigned sum.
- R4: With mode = 1, result equals (A - B) mod 2^N, and the carry_in input has no effect on result or carry_out.
- R5: With mode = 1, carry_out is 1 exactly when A >= B (unsigned), meaning no borrow.
- R6: The garbage vector is laid out as follows:
  - bit 2i holds the pass-through copy of A[i];
  - bit 2i+1 holds the conditioned B bit i (B[i] XOR mode);
  - bit 2N holds the mode copy at the end of the XOR-gate chain.
- R7: For N = 16 the exposed constants are 24 gates, 16 ancillas, 33 garbage bits and a quantum cost of 112. In general they are N+N/2, N, 2N+1 and 7N.
- R8: N must be even and at least 2. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| mode | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Carry into bit 0 in add mode |
| result | output | N | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit (no-borrow flag when subtracting) |
| garbage | output | 2N+1 | Unused gate outputs in fixed order |

## Verification
Assertions embedded in the RTL evaluate whenever the inputs change. They cover:
- the end-to-end sum in add mode;
- the difference and no-borrow flag in subtract mode;
- the inversion performed by the XOR gate row;
- the pass-through of A and conditioned B onto the garbage vector.

The bench covers what those assertions cannot. It drives each primitive through its whole input space to show that it is a one-to-one mapping. It checks the elaboration constants against the closed-form counts. It also checks that carry_in has no effect in subtract mode, using the listed operand pairs, random values and the all-zero and all-one corners.

// File: rtl/rev_pkg.sv
package rev_pkg;

    typedef struct packed {
        logic ctl;
        logic x1;
        logic x2;
    } dxor_out_t;

    typedef struct packed {
        logic pa;
        logic pb;
        logic sum;
        logic carry;
    } fadd_out_t;

    localparam int DXOR_QCOST = 2;
    localparam int FADD_QCOST = 6;

    function automatic int metric_gates(input int n);
        return n + n / 2;
    endfunction

    function automatic int metric_ancilla(input int n);
        return n;
    endfunction

    function automatic int metric_garbage(input int n);
        return 2 * n + 1;
    endfunction

    function automatic int metric_qcost(input int n);
        return (n / 2) * DXOR_QCOST + n * FADD_QCOST;
    endfunction

endpackage

// File: rtl/rev_dxor_gate.sv
module rev_dxor_gate
    import rev_pkg::*;
(
    input  logic      p_a,
    input  logic      p_b,
    input  logic      p_c,
    output dxor_out_t q
);
    always_comb begin
        q.ctl = p_a;
        q.x1  = p_a ^ p_b;
        q.x2  = p_a ^ p_c;
    end
endmodule

// File: rtl/rev_fadd_gate.sv
module rev_fadd_gate
    import rev_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      c,
    input  logic      d,
    output fadd_out_t q
);
    always_comb begin
        q.pa    = a;
        q.pb    = b;
        q.sum   = a ^ b ^ c;
        q.carry = ((a ^ b) & c) ^ (a & b) ^ d;
    end
endmodule

// File: rtl/rev_bcond.sv
module rev_bcond
    import rev_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         ctrl,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] b_cond,
    output logic         ctrl_tail
);
    localparam int PAIRS = N / 2;

    logic [PAIRS:0]  ctl_chain;
    dxor_out_t       gate_q [PAIRS];

    assign ctl_chain[0] = ctrl;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        rev_dxor_gate u_dxor (
            .p_a (ctl_chain[k]),
            .p_b (b_in[2*k]),
            .p_c (b_in[2*k+1]),
            .q   (gate_q[k])
        );
        assign ctl_chain[k+1] = gate_q[k].ctl;
        assign b_cond[2*k]    = gate_q[k].x1;
        assign b_cond[2*k+1]  = gate_q[k].x2;
    end

    assign ctrl_tail = ctl_chain[PAIRS];

    // R1: conditioned operand follows the mode
    always_comb begin
        if (ctrl) a_r1_cond_invert: assert (b_cond == ~b_in);
        else      a_r1_cond_pass:   assert (b_cond == b_in);
    end
endmodule

// File: rtl/rev_ripple.sv
module rev_ripple
    import rev_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic         c_in,
    output logic [N-1:0] sum,
    output logic         c_out,
    output logic [N-1:0] pass_a,
    output logic [N-1:0] pass_b
);
    localparam logic ANCILLA = 1'b0;

    logic [N:0] carry;
    fadd_out_t  cell_q [N];

    assign carry[0] = c_in;

    for (genvar i = 0; i < N; i++) begin : g_bit
        rev_fadd_gate u_fadd (
            .a (a_in[i]),
            .b (b_in[i]),
            .c (carry[i]),
            .d (ANCILLA),
            .q (cell_q[i])
        );
        assign sum[i]     = cell_q[i].sum;
        assign carry[i+1] = cell_q[i].carry;
        assign pass_a[i]  = cell_q[i].pa;
        assign pass_b[i]  = cell_q[i].pb;
    end

    assign c_out = carry[N];

    // R2: gate row leaves operands intact and yields the arithmetic sum
    always_comb begin
        a_r2_passthrough: assert (pass_a == a_in && pass_b == b_in);
        a_r2_row_sum: assert ({c_out, sum} ==
            ({1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, c_in}));
    end
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub
    import rev_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    input  logic           mode,
    input  logic           carry_in,
    output logic [N-1:0]   result,
    output logic           carry_out,
    output logic [2*N:0]   garbage
);
    localparam int GATE_COUNT    = metric_gates(N);
    localparam int ANCILLA_COUNT = metric_ancilla(N);
    localparam int GARBAGE_COUNT = metric_garbage(N);
    localparam int QUANTUM_COST  = metric_qcost(N);

    // R8: width legality
    if ((N % 2) != 0 || N < 2) begin : g_bad_width
        $error("rev_addsub: N must be even and at least 2");
    end

    logic [N-1:0] b_cond;
    logic         ctrl_tail;
    logic         first_carry;
    logic [N-1:0] pass_a;
    logic [N-1:0] pass_b;

    rev_bcond #(.N(N)) u_bcond (
        .ctrl      (mode),
        .b_in      (op_b),
        .b_cond    (b_cond),
        .ctrl_tail (ctrl_tail)
    );

    assign first_carry = mode | carry_in;

    rev_ripple #(.N(N)) u_ripple (
        .a_in   (op_a),
        .b_in   (b_cond),
        .c_in   (first_carry),
        .sum    (result),
        .c_out  (carry_out),
        .pass_a (pass_a),
        .pass_b (pass_b)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            garbage[2*i]   = pass_a[i];
            garbage[2*i+1] = pass_b[i];
        end
        garbage[2*N] = ctrl_tail;
    end

    always_comb begin
        if (!mode) begin
            // R3
            a_r3_add: assert ({carry_out, result} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in}));
        end else begin
            // R4
            a_r4_sub: assert (result == (op_a - op_b));
            // R5
            a_r5_no_borrow: assert (carry_out == (op_a >= op_b));
        end
        // R6
        a_r6_garbage_tail: assert (garbage[2*N] == mode);
    end
endmodule

// File: tb/rev_addsub_bench.sv
`timescale 1ns/1ps
module rev_addsub_bench;
    import rev_pkg::*;

    localparam int N = 16;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic         m;
        logic         ci;
        logic [N-1:0] res;
        logic         co;
        logic [2*N:0] garb;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [N-1:0] op_a = '0, op_b = '0;
    logic mode = 1'b0, carry_in = 1'b0;
    logic [N-1:0] result;
    logic carry_out;
    logic [2*N:0] garbage;

    rev_addsub #(.N(N)) u_rev_addsub (
        .op_a(op_a), .op_b(op_b), .mode(mode), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .garbage(garbage)
    );

    logic g_p = 0, g_q = 0, g_r = 0;
    dxor_out_t g_dq;
    rev_dxor_gate u_dxor_chk (.p_a(g_p), .p_b(g_q), .p_c(g_r), .q(g_dq));

    logic f_a = 0, f_b = 0, f_c = 0, f_d = 0;
    fadd_out_t f_q;
    rev_fadd_gate u_fadd_chk (.a(f_a), .b(f_b), .c(f_c), .d(f_d), .q(f_q));

    exp_t sb[$];

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic m, input logic ci);
        exp_t e;
        logic [N:0] s;
        @(negedge clk);
        op_a = a; op_b = b; mode = m; carry_in = ci;
        e.a = a; e.b = b; e.m = m; e.ci = ci;
        if (!m) begin
            s = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
            e.res = s[N-1:0];
            e.co  = s[N];
        end else begin
            e.res = a - b;
            e.co  = (a >= b);
        end
        for (int i = 0; i < N; i++) begin
            e.garb[2*i]   = a[i];
            e.garb[2*i+1] = b[i] ^ m;
        end
        e.garb[2*N] = m;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (!e.m) begin
                    check(result == e.res && carry_out == e.co, "R3 add",
                          {47'b0, carry_out, result}, {47'b0, e.co, e.res});
                end else begin
                    check(result == e.res, "R4 sub result",
                          {48'b0, result}, {48'b0, e.res});
                    check(carry_out == e.co, "R5 no-borrow",
                          {63'b0, carry_out}, {63'b0, e.co});
                end
                check(garbage == e.garb, "R6 garbage order",
                      {31'b0, garbage}, {31'b0, e.garb});
            end
        end
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  seen8;
        logic [15:0] seen16;
        logic [2:0]  o3;
        logic [3:0]  o4;
        logic [N-1:0] ra, rb;

        // R7 metrics
        check(u_rev_addsub.GATE_COUNT == 24, "R7 gates", 64'(u_rev_addsub.GATE_COUNT), 64'd24);
        check(u_rev_addsub.ANCILLA_COUNT == 16, "R7 ancilla", 64'(u_rev_addsub.ANCILLA_COUNT), 64'd16);
        check(u_rev_addsub.GARBAGE_COUNT == 33, "R7 garbage", 64'(u_rev_addsub.GARBAGE_COUNT), 64'd33);
        check(u_rev_addsub.QUANTUM_COST == 112, "R7 qcost", 64'(u_rev_addsub.QUANTUM_COST), 64'd112);
        check($bits(garbage) == 33, "R8 garbage width", 64'($bits(garbage)), 64'd33);

        // R1 exhaustive
        seen8 = '0;
        for (int v = 0; v < 8; v++) begin
            {g_p, g_q, g_r} = v[2:0];
            #1;
            o3 = {g_dq.ctl, g_dq.x1, g_dq.x2};
            check(o3 == {g_p, g_p ^ g_q, g_p ^ g_r}, "R1 xor map",
                  64'(o3), 64'({g_p, g_p ^ g_q, g_p ^ g_r}));
            check(!seen8[o3], "R1 bijective", 64'(o3), 64'(v));
            seen8[o3] = 1'b1;
        end
        check(seen8 == 8'hFF, "R1 all outputs", 64'(seen8), 64'hFF);

        // R2 exhaustive
        seen16 = '0;
        for (int v = 0; v < 16; v++) begin
            logic [3:0] ex;
            {f_a, f_b, f_c, f_d} = v[3:0];
            #1;
            o4 = {f_q.pa, f_q.pb, f_q.sum, f_q.carry};
            ex = {f_a, f_b, f_a ^ f_b ^ f_c, ((f_a ^ f_b) & f_c) ^ (f_a & f_b) ^ f_d};
            check(o4 == ex, "R2 fadd map", 64'(o4), 64'(ex));
            check(!seen16[o4], "R2 bijective", 64'(o4), 64'(v));
            seen16[o4] = 1'b1;
        end
        check(seen16 == 16'hFFFF, "R2 all outputs", 64'(seen16), 64'hFFFF);

        // reset / idle state: zero inputs
        @(negedge clk);
        check(result == '0 && carry_out == 1'b0 && garbage == '0, "R3 idle zero",
              {31'b0, garbage}, 64'd0);

        // listed vectors
        drive(16'h0042, 16'h0016, 1'b0, 1'b0);
        drive(16'h0042, 16'h0016, 1'b0, 1'b1);
        drive(16'h127D, 16'h0123, 1'b0, 1'b0);
        drive(16'h34FF, 16'h12AA, 1'b0, 1'b0);
        drive(16'h0097, 16'h0077, 1'b1, 1'b1);
        drive(16'h0A28, 16'h0200, 1'b1, 1'b1);
        drive(16'h0BC9, 16'h0AB8, 1'b1, 1'b1);
        drive(16'hFFFF, 16'hDCBA, 1'b1, 1'b1);
        // R4: carry_in ignored when subtracting
        drive(16'h0BC9, 16'h0AB8, 1'b1, 1'b0);
        drive(16'h0005, 16'h0009, 1'b1, 1'b0);
        // corners
        drive(16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
        drive(16'hFFFF, 16'h0000, 1'b0, 1'b1);
        drive(16'h0000, 16'h0000, 1'b1, 1'b0);
        drive(16'h0000, 16'hFFFF, 1'b1, 1'b1);
        drive(16'h8000, 16'h8000, 1'b1, 1'b0);
        drive(16'h1234, 16'h1235, 1'b1, 1'b1);

        void'($urandom(32'h5EED));
        for (int k = 0; k < 400; k++) begin
            ra = N'($urandom);
            rb = N'($urandom);
            drive(ra, rb, k[0], k[1]);
        end

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        // spot check after queue drained
        check(result == (op_a - op_b) || !mode, "R4 final",
              {48'b0, result}, {48'b0, op_a - op_b});
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule